// File: doc/BRIEF.md
# Escaped Byte-Stream Message Deframer

This block takes bytes from a receive FIFO and rebuilds fixed-width command messages from framed, byte-stuffed traffic. Each frame opens with a start code and closes with a stop code. Inside a frame an escape code marks the next byte as plain payload, so payload bytes that equal a control code still pass through. The block reads the FIFO through a first-word-fall-through port with an empty flag and a dequeue pulse. Each finished message is offered on a valid/ready style output and held there until the consumer takes it.

Back-pressure on the output works as follows. `msg_valid` rises once a frame completes. From then on `msg` stays fixed and the FIFO is not read. In any cycle where `msg_valid` and `msg_take` are both high, the message is consumed and `msg_valid` falls at the next edge. `msg_take` has no effect while `msg_valid` is low. The FIFO data port must show the head byte whenever `fifo_empty` is low. A dequeue pulse consumes that byte at the same clock edge.

Top module: `esc_frame_deframer`

## Requirements
- R1: The control codes are start 0x12, stop 0x13 and escape 0x7D. A message is delivered for a start code, followed by exactly PAY_BYTES payload bytes (6 with the default widths), followed by an unescaped stop code.
- R2: While no frame is open, bytes are thrown away. An escape byte seen in that state also causes the byte after it to be thrown away, so an escaped 0x12 does not open a frame.
- R3: An unescaped 0x12 inside an open frame discards the bytes collected so far and opens a new frame.
- R4: The byte right after an unescaped escape byte inside a frame is stored as payload, whatever its value. The escape byte itself is not stored.
- R5: Payload arrives most significant byte first. The low OPC_W bits of byte 0 form the opcode and its upper bits are ignored. The next bytes carry the address and the last bytes carry the data. The output is msg = {opcode, address, data}, so with the defaults the opcode is at bits 43:40, the address at bits 39:8 and the data at bits 7:0.
- R6: A frame whose payload byte count differs from PAY_BYTES, including an empty frame, is dropped and `msg_valid` does not rise.
- R7: While `msg_valid` is high and `msg_take` is low, `msg_valid` stays high and `msg` does not change.
- R8: `msg_take` together with `msg_valid` clears `msg_valid` at the next edge. `msg_take` while `msg_valid` is low is ignored.
- R9: `fifo_deq` is high exactly when `fifo_empty` is low and no message is waiting. Each pulse consumes one byte.
- R10: After a synchronous active-low reset, `msg_valid` is low and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_byte | input | 8 | Head byte of the receive FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_deq | output | 1 | Consume the head byte at this edge |
| msg | output | OPC_W+ADDR_W+DATA_W | Assembled message |
| msg_valid | output | 1 | A message is waiting |
| msg_take | input | 1 | Consumer accepts the waiting message |

## Verification
The opcode byte and the data byte are each swept over all 256 values. This separates correct escaping of the three control codes from plain storage, and shows that the upper opcode bits are ignored. Each control code is also placed in every address byte, which checks byte order and field placement. Three kinds of malformed traffic are sent: noise before a frame, an escaped start while hunting, and short, long and empty frames. Each must produce no message, and the frame that follows must still arrive. That frame distinguishes proper resynchronisation from a stuck state machine. The consumer delays its take by a varying number of cycles, which tests that the message holds and that the FIFO is stalled.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam logic [7:0] SOF_CODE = 8'h12;
  localparam logic [7:0] EOF_CODE = 8'h13;
  localparam logic [7:0] ESC_CODE = 8'h7D;

  typedef enum logic [1:0] {
    ST_HUNT     = 2'd0,
    ST_HUNT_ESC = 2'd1,
    ST_BODY     = 2'd2,
    ST_BODY_ESC = 2'd3
  } dfr_state_t;
endpackage

// File: rtl/dfr_byte_class.sv
module dfr_byte_class
  import dfr_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       is_sof,
  output logic       is_eof,
  output logic       is_esc
);
  always_comb begin
    is_sof = (byte_in == SOF_CODE);
    is_eof = (byte_in == EOF_CODE);
    is_esc = (byte_in == ESC_CODE);
  end
endmodule

// File: rtl/dfr_collect.sv
module dfr_collect
  import dfr_pkg::*;
#(
  parameter int PAY_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             fifo_byte,
  input  logic                   fifo_empty,
  input  logic                   hold,
  input  logic                   is_sof,
  input  logic                   is_eof,
  input  logic                   is_esc,
  output logic                   fifo_deq,
  output logic                   done,
  output logic [PAY_BYTES*8-1:0] payload
);
  localparam int CNT_W = $clog2(PAY_BYTES + 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PAY_BYTES);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(PAY_BYTES + 1);

  dfr_state_t       st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic             fire, store, clear;

  assign fire     = !fifo_empty && !hold;
  assign fifo_deq = fire;

  always_comb begin
    st_nx = st;
    store = 1'b0;
    clear = 1'b0;
    done  = 1'b0;
    if (fire) begin
      unique case (st)
        ST_HUNT: begin
          if (is_sof) begin
            st_nx = ST_BODY;
            clear = 1'b1;
          end else if (is_esc) begin
            st_nx = ST_HUNT_ESC;
          end
        end
        ST_HUNT_ESC: st_nx = ST_HUNT;
        ST_BODY: begin
          if (is_sof) begin
            clear = 1'b1;
          end else if (is_eof) begin
            st_nx = ST_HUNT;
            done  = (cnt == FULL_CNT);
          end else if (is_esc) begin
            st_nx = ST_BODY_ESC;
          end else begin
            store = 1'b1;
          end
        end
        ST_BODY_ESC: begin
          st_nx = ST_BODY;
          store = 1'b1;
        end
        default: st_nx = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      payload <= '0;
    end else begin
      st <= st_nx;
      if (clear) begin
        cnt <= '0;
      end else if (store) begin
        if (cnt < FULL_CNT) begin
          payload <= {payload[PAY_BYTES*8-9:0], fifo_byte};
          cnt     <= cnt + 1'b1;
        end else begin
          cnt <= OVER_CNT;
        end
      end
    end
  end

  // R4: an escaped byte inside a frame always returns the machine to the body state
  a_r4_esc_returns_body: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY_ESC && fire) |=> (st == ST_BODY));
  // R2: an escape seen while hunting swallows exactly one byte and keeps hunting
  a_r2_hunt_esc_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT_ESC && fire) |=> (st == ST_HUNT));
endmodule

// File: rtl/dfr_out.sv
module dfr_out #(
  parameter int PAY_BYTES = 6,
  parameter int OPC_W     = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 8,
  parameter int ADDR_BY   = 4,
  parameter int DATA_BY   = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           done,
  input  logic [PAY_BYTES*8-1:0]         payload,
  input  logic                           msg_take,
  output logic [OPC_W+ADDR_W+DATA_W-1:0] msg,
  output logic                           msg_valid
);
  localparam int MSG_W = OPC_W + ADDR_W + DATA_W;

  logic [MSG_W-1:0] packed_msg;
  assign packed_msg = {payload[PAY_BYTES*8-8 +: OPC_W],
                       payload[DATA_BY*8 +: ADDR_W],
                       payload[0 +: DATA_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg       <= '0;
    end else if (done) begin
      msg_valid <= 1'b1;
      msg       <= packed_msg;
    end else if (msg_valid && msg_take) begin
      msg_valid <= 1'b0;
    end
  end

  // R7: a waiting message holds until taken
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_take) |=> (msg_valid && $stable(msg)));
  // R8: a take of a waiting message releases it
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_take) |=> !msg_valid);
endmodule

// File: rtl/esc_frame_deframer.sv
module esc_frame_deframer #(
  parameter int OPC_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [7:0]                     fifo_byte,
  input  logic                           fifo_empty,
  output logic                           fifo_deq,
  output logic [OPC_W+ADDR_W+DATA_W-1:0] msg,
  output logic                           msg_valid,
  input  logic                           msg_take
);
  localparam int ADDR_BY   = (ADDR_W + 7) / 8;
  localparam int DATA_BY   = (DATA_W + 7) / 8;
  localparam int PAY_BYTES = 1 + ADDR_BY + DATA_BY;

  logic                   is_sof, is_eof, is_esc, done;
  logic [PAY_BYTES*8-1:0] payload;

  dfr_byte_class u_class (
    .byte_in (fifo_byte),
    .is_sof  (is_sof),
    .is_eof  (is_eof),
    .is_esc  (is_esc)
  );

  dfr_collect #(.PAY_BYTES(PAY_BYTES)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_byte  (fifo_byte),
    .fifo_empty (fifo_empty),
    .hold       (msg_valid),
    .is_sof     (is_sof),
    .is_eof     (is_eof),
    .is_esc     (is_esc),
    .fifo_deq   (fifo_deq),
    .done       (done),
    .payload    (payload)
  );

  dfr_out #(
    .PAY_BYTES(PAY_BYTES), .OPC_W(OPC_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .ADDR_BY(ADDR_BY), .DATA_BY(DATA_BY)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .payload   (payload),
    .msg_take  (msg_take),
    .msg       (msg),
    .msg_valid (msg_valid)
  );

  // R9: no byte is pulled while a message waits
  a_r9_stall_pull: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !fifo_deq);
  // R6: a message only appears right after a consumed byte
  a_r6_rise_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(fifo_deq));
endmodule

// File: tb/esc_frame_deframer_test.sv
module esc_frame_deframer_test;
  localparam int MSG_W = 44;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       fifo_mem [0:4095];
  logic [11:0]      wr = '0, rd = '0;
  logic             fifo_empty, fifo_deq, msg_valid;
  logic [7:0]       fifo_byte;
  logic [MSG_W-1:0] msg;
  logic             take_c = 1'b0, take_i = 1'b0, msg_take;
  logic [MSG_W-1:0] expq [$];
  int               n_tests = 0, n_fail = 0, cycles = 0, lag = 0, lag_cnt = 0, got = 0;

  always #2 clk = ~clk;

  assign fifo_empty = (wr == rd);
  assign fifo_byte  = fifo_mem[rd];
  assign msg_take   = take_c | take_i;

  esc_frame_deframer uut (
    .clk(clk), .rst_n(rst_n), .fifo_byte(fifo_byte), .fifo_empty(fifo_empty),
    .fifo_deq(fifo_deq), .msg(msg), .msg_valid(msg_valid), .msg_take(msg_take)
  );

  always @(posedge clk) if (rst_n && fifo_deq) rd <= rd + 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // consumer: checks content while holding, takes after 'lag' cycles
  always @(negedge clk) begin
    take_c = 1'b0;
    if (rst_n) begin
      chk(fifo_deq === (!fifo_empty && !msg_valid), "R9 deq rule", fifo_deq, !fifo_empty && !msg_valid);
      if (msg_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R6 unexpected message", msg, 0);
          take_c = 1'b1;
        end else begin
          chk(msg === expq[0], "R5 R4 R7 message content", msg, expq[0]);
          if (lag_cnt >= lag) begin
            void'(expq.pop_front());
            take_c  = 1'b1;
            lag_cnt = 0;
            got++;
            lag = got % 4;
          end else lag_cnt++;
        end
      end
    end
  end

  task automatic push(input logic [7:0] b);
    fifo_mem[wr] = b;
    wr = wr + 1'b1;
  endtask

  task automatic put(input logic [7:0] b);
    if (b == 8'h12 || b == 8'h13 || b == 8'h7D) push(8'h7D);
    push(b);
  endtask

  task automatic send(input logic [7:0] ob, input logic [31:0] ad, input logic [7:0] dt, input bit expect_it);
    push(8'h12);
    put(ob);
    for (int i = 3; i >= 0; i--) put(ad[i*8 +: 8]);
    put(dt);
    push(8'h13);
    if (expect_it) expq.push_back({ob[3:0], ad, dt});
  endtask

  task automatic drain();
    int t = 0;
    while ((wr != rd || expq.size() != 0 || msg_valid) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic quiet(input string req);
    drain();
    chk(msg_valid === 1'b0 && expq.size() == 0, req, msg_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(msg_valid === 1'b0, "R10 valid after reset", msg_valid, 0);
    chk(fifo_deq === 1'b0, "R10 deq with empty fifo", fifo_deq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: take with nothing waiting is ignored
    take_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(msg_valid === 1'b0, "R8 stray take", msg_valid, 0);
    take_i = 1'b0;

    // R1 basic frame
    send(8'h0A, 32'hDEADBEEF, 8'h5C, 1);
    drain();
    chk(got == 1, "R1 basic frame delivered", got, 1);

    // R4 R5: full data and opcode sweeps
    for (int v = 0; v < 256; v++) send(8'h03, 32'h01020304, v[7:0], 1);
    drain();
    for (int v = 0; v < 256; v++) send(v[7:0], 32'hA0B0C0D0, 8'h11, 1);
    drain();
    // R5: each control code in every address byte
    for (int p = 0; p < 4; p++) begin
      send(8'h01, 32'h12 << (p*8), 8'h7D, 1);
      send(8'h02, 32'h13 << (p*8), 8'h12, 1);
      send(8'h04, 32'h7D << (p*8), 8'h13, 1);
    end
    drain();
    chk(got == 1 + 512 + 12, "R5 all sweeps delivered", got, 525);

    // R2: noise before a frame, then escaped start while hunting
    push(8'h13); push(8'h55); push(8'h00);
    push(8'h7D); push(8'h12);
    for (int i = 0; i < 6; i++) push(8'h40 + i[7:0]);
    push(8'h13);
    quiet("R2 no frame from noise or escaped start");
    send(8'h06, 32'h11223344, 8'h66, 1);
    drain();
    chk(got == 526, "R2 frame after noise", got, 526);

    // R3: restart mid frame
    push(8'h12); push(8'h21); push(8'h22); push(8'h23);
    send(8'h07, 32'h55667788, 8'h99, 1);
    drain();
    chk(got == 527, "R3 restart keeps only new frame", got, 527);

    // R6: short, long and empty frames
    push(8'h12); for (int i = 0; i < 5; i++) push(8'h30); push(8'h13);
    quiet("R6 short frame dropped");
    push(8'h12); for (int i = 0; i < 7; i++) push(8'h31); push(8'h13);
    quiet("R6 long frame dropped");
    push(8'h12); push(8'h13);
    quiet("R6 empty frame dropped");
    send(8'h08, 32'h0BADF00D, 8'h42, 1);
    drain();
    chk(got == 528, "R6 recovery after bad frames", got, 528);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule